// File: doc/BRIEF.md
# Interleaved Parity Protected Memory

This block is a single-port synchronous memory with parity protection built around it. A write stores a data row together with one even-parity bit for each of several parity groups. The groups do not take contiguous slices of the row. Bit p of the row belongs to group p mod N, so the bits of every group are spread across the whole row. If a physical fault flips a run of neighbouring bits, and the run is no longer than N, each flipped bit lands in a different group. The read check then reports the fault as single-bit mismatches in distinct groups rather than missing it as an even count inside one group.

A read returns the stored row one cycle after the request. It also returns a vector with one mismatch bit per group. A sticky flag records that some read has seen a mismatch, and it stays set until it is cleared on purpose.

Two test pulses exist so that error-handling software can be exercised without real faults. The first pulse arms a corruption of the parity stored by the next write. The second arms a corruption of the parity checked by the next read, and it leaves the stored row unchanged. A mask that comes with each pulse selects which groups are affected.

Top module: `ilv_parity_mem`

## Requirements
- R1: A read request (reqValid=1, reqWrite=0) drives rdValid high for exactly the following cycle. In that cycle rdData carries the row most recently written to that address. While rdValid is low, rdData holds its value.
- R2: Parity is even per group. A read of a row that was written without injection and has not been disturbed reports rdWordErr = 0.
- R3: Row bit p belongs to group p mod ILV (ILV defaults to 4, and DATA_W is a multiple of ILV). A single flipped stored data bit p sets only rdWordErr[p mod ILV].
- R4: A run of k adjacent flipped stored data bits, with k <= ILV and the run starting at bit s, sets exactly the k group bits (s+i) mod ILV for i = 0..k-1. For example, 4 bits from bit 5 give 4'b1111, and 3 bits from bit 9 give 4'b1110.
- R5: A pulse on injWr arms write injection with injMask. The next write stores the parity of the groups set in that mask inverted, while the data is stored unchanged. Every later read of that row reports rdWordErr equal to that mask. A pulse in the same cycle as a write applies to that write. Writes after the consuming write are clean.
- R6: A pulse on injRd arms read injection with injMask. The next read reports rdWordErr equal to that mask, and the stored row is not changed. A second read of the same row reports 0. A pulse in the same cycle as a read applies to that read.
- R7: errSticky rises in the cycle after a cycle that has rdValid=1 and a nonzero rdWordErr. It stays high while errClear is low.
- R8: errClear drops errSticky in the next cycle. A mismatch seen in the same cycle as errClear takes priority, and the flag stays high.
- R9: After reset, rdValid=0, errSticky=0, rdWordErr=0, and no injection is armed.
- R10: An armed write injection is not consumed by reads. An armed read injection is not consumed by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Row address |
| reqWdata | input | DATA_W | Write data |
| injWr | input | 1 | Arm parity corruption of the next write |
| injRd | input | 1 | Arm parity corruption of the next read check |
| injMask | input | ILV | Groups affected by an injection pulse |
| errClear | input | 1 | Clear the sticky error flag |
| rdValid | output | 1 | Read result valid |
| rdData | output | DATA_W | Read data |
| rdWordErr | output | ILV | Per-group parity mismatch for the read |
| errSticky | output | 1 | Sticky record of any read mismatch |

## Verification
The bench builds the block with its default values: 32-bit rows, 4 interleaved groups and 16 rows. With 4 groups, every residue class of the bit-to-group mapping can be reached by a few single-bit faults, and full-width and partial bursts can be placed at offsets that wrap across the group order. Faults are emulated by overwriting a stored row with a known-good parity field and deliberately flipped data. This makes the expected mismatch vector a pure function of the flipped positions.

// File: rtl/ilvpar_pkg.sv
package ilvpar_pkg;
  // Strobes sent from control to datapath for one access cycle.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } memStrobe_t;
endpackage

// File: rtl/ilvpar_gen.sv
module ilvpar_gen #(
  parameter int DATA_W = 32,
  parameter int ILV    = 4
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [ILV-1:0]    parOut
);
  localparam int WORD_BITS = DATA_W / ILV;

  // Group g collects row bits g, g+ILV, g+2*ILV, ...
  for (genvar g = 0; g < ILV; g++) begin : gWord
    logic [WORD_BITS-1:0] wordBits;
    for (genvar j = 0; j < WORD_BITS; j++) begin : gBit
      assign wordBits[j] = dataIn[j*ILV + g];
    end
    assign parOut[g] = ^wordBits;
  end
endmodule

// File: rtl/ilvpar_ctrl.sv
module ilvpar_ctrl
  import ilvpar_pkg::*;
#(
  parameter int ILV = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic           reqWrite,
  input  logic           injWr,
  input  logic           injRd,
  input  logic [ILV-1:0] injMask,
  input  logic           errClear,
  input  logic           errAny,
  output memStrobe_t     strobe,
  output logic [ILV-1:0] wrFlip,
  output logic [ILV-1:0] rdFlip,
  output logic           rdValid,
  output logic           errSticky
);
  logic [ILV-1:0] wrArmQ;
  logic [ILV-1:0] rdArmQ;

  assign strobe.wrEn = reqValid & reqWrite;
  assign strobe.rdEn = reqValid & ~reqWrite;

  // A pulse coinciding with the access applies to that access.
  assign wrFlip = strobe.wrEn ? (injWr ? injMask : wrArmQ) : '0;
  assign rdFlip = strobe.rdEn ? (injRd ? injMask : rdArmQ) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrArmQ    <= '0;
      rdArmQ    <= '0;
      rdValid   <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.wrEn)   wrArmQ <= '0;
      else if (injWr)    wrArmQ <= injMask;

      if (strobe.rdEn)   rdArmQ <= '0;
      else if (injRd)    rdArmQ <= injMask;

      rdValid <= strobe.rdEn;

      if (rdValid && errAny) errSticky <= 1'b1;
      else if (errClear)     errSticky <= 1'b0;
    end
  end
endmodule

// File: rtl/ilvpar_dp.sv
module ilvpar_dp
  import ilvpar_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ILV    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ILV-1:0]    wrFlip,
  input  logic [ILV-1:0]    rdFlip,
  output logic [DATA_W-1:0] rdData,
  output logic [ILV-1:0]    wordErr,
  output logic              errAny
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = DATA_W + ILV;

  logic [ROW_W-1:0]  memArr [DEPTH];
  logic [ILV-1:0]    wrPar;
  logic [ILV-1:0]    rdParCalc;
  logic [ILV-1:0]    rdParQ;
  logic [DATA_W-1:0] rdDataQ;

  ilvpar_gen #(.DATA_W(DATA_W), .ILV(ILV)) uWrGen (.dataIn(wdata),   .parOut(wrPar));
  ilvpar_gen #(.DATA_W(DATA_W), .ILV(ILV)) uRdGen (.dataIn(rdDataQ), .parOut(rdParCalc));

  always_ff @(posedge clk) begin
    if (strobe.wrEn) memArr[addr] <= {wrPar ^ wrFlip, wdata};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
      rdParQ  <= '0;
    end else if (strobe.rdEn) begin
      rdDataQ <= memArr[addr][DATA_W-1:0];
      rdParQ  <= memArr[addr][ROW_W-1:DATA_W] ^ rdFlip;
    end
  end

  assign rdData  = rdDataQ;
  assign wordErr = rdParCalc ^ rdParQ;
  assign errAny  = |wordErr;
endmodule

// File: rtl/ilv_parity_mem.sv
module ilv_parity_mem
  import ilvpar_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ILV    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              injWr,
  input  logic              injRd,
  input  logic [ILV-1:0]    injMask,
  input  logic              errClear,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ILV-1:0]    rdWordErr,
  output logic              errSticky
);
  memStrobe_t     strobe;
  logic [ILV-1:0] wrFlip;
  logic [ILV-1:0] rdFlip;
  logic           errAny;

  ilvpar_ctrl #(.ILV(ILV)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .injWr(injWr), .injRd(injRd), .injMask(injMask), .errClear(errClear),
    .errAny(errAny), .strobe(strobe), .wrFlip(wrFlip), .rdFlip(rdFlip),
    .rdValid(rdValid), .errSticky(errSticky)
  );

  ilvpar_dp #(.DATA_W(DATA_W), .ILV(ILV), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(reqAddr),
    .wdata(reqWdata), .wrFlip(wrFlip), .rdFlip(rdFlip),
    .rdData(rdData), .wordErr(rdWordErr), .errAny(errAny)
  );
endmodule

// File: rtl/ilvpar_chk.sv
module ilvpar_chk #(
  parameter int DATA_W = 32,
  parameter int ILV    = 4,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              errClear,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [ILV-1:0]    rdWordErr,
  input logic              errSticky
);
  p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdValid);
  p_rd_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rdValid);
  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdData));
  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && (rdWordErr != '0)) |=> errSticky);
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !errClear) |=> errSticky);
  p_sticky_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSticky) |-> $past(rdValid && (rdWordErr != '0)));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !(rdValid && (rdWordErr != '0))) |=> !errSticky);
endmodule

bind ilv_parity_mem ilvpar_chk #(.DATA_W(DATA_W), .ILV(ILV), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .errClear(errClear), .rdValid(rdValid), .rdData(rdData),
  .rdWordErr(rdWordErr), .errSticky(errSticky)
);

// File: tb/tb_ilv_parity_mem.sv
module tb_ilv_parity_mem;
  localparam int DATA_W = 32;
  localparam int ILV    = 4;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid, reqWrite, injWr, injRd, errClear;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [ILV-1:0]    injMask;
  logic              rdValid, errSticky;
  logic [DATA_W-1:0] rdData;
  logic [ILV-1:0]    rdWordErr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ilv_parity_mem #(.DATA_W(DATA_W), .ILV(ILV), .ADDR_W(ADDR_W)) dut (.*);

  function automatic logic [ILV-1:0] evenPar(input logic [DATA_W-1:0] d);
    logic [ILV-1:0] p = '0;
    for (int i = 0; i < DATA_W; i++) p[i % ILV] = p[i % ILV] ^ d[i];
    return p;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqWrite = 0; injWr = 0; injRd = 0; errClear = 0; injMask = '0;
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic inj, input logic [ILV-1:0] m);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d; injWr = inj; injMask = m;
    @(negedge clk);
    idle();
  endtask

  // Issues a read; optionally clears sticky in the rdValid cycle. Returns outputs sampled in that cycle.
  task automatic doRead(input logic [ADDR_W-1:0] a, input logic clr,
                        output logic [DATA_W-1:0] d, output logic [ILV-1:0] e, output logic v);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    idle();
    errClear = clr;
    v = rdValid; d = rdData; e = rdWordErr;
    @(negedge clk);
    errClear = 0;
  endtask

  task automatic pulse(input logic w, input logic r, input logic [ILV-1:0] m);
    @(negedge clk);
    injWr = w; injRd = r; injMask = m;
    @(negedge clk);
    idle();
  endtask

  task automatic clearSticky();
    @(negedge clk); errClear = 1;
    @(negedge clk); errClear = 0;
    check("R8", "sticky after clear", errSticky, 0);
  endtask

  task automatic corrupt(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] good,
                         input logic [DATA_W-1:0] flips);
    @(negedge clk);
    dut.uDp.memArr[a] = {evenPar(good), good ^ flips};
  endtask

  task automatic testReset();
    check("R9", "rdValid", rdValid, 0);
    check("R9", "errSticky", errSticky, 0);
    check("R9", "rdWordErr", rdWordErr, 0);
  endtask

  task automatic testBasic();
    logic [DATA_W-1:0] d; logic [ILV-1:0] e; logic v;
    logic [DATA_W-1:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F71, 32'h1234_5678};
    for (int i = 0; i < 4; i++) doWrite(ADDR_W'(i + 2), pats[i], 0, '0);
    for (int i = 0; i < 4; i++) begin
      doRead(ADDR_W'(i + 2), 0, d, e, v);
      check("R1", "rdValid", v, 1);
      check("R1", "rdData", d, pats[i]);
      check("R2", "clean word err", e, 0);
      check("R1", "rdValid one cycle", rdValid, 0);
      check("R1", "rdData held", rdData, pats[i]);
    end
    check("R2", "sticky after clean reads", errSticky, 0);
  endtask

  task automatic testSingleBit();
    logic [DATA_W-1:0] d; logic [ILV-1:0] e; logic v;
    logic [DATA_W-1:0] good = 32'h3C96_E11B;
    doWrite(7, good, 0, '0);
    for (int p = 0; p < 8; p++) begin
      corrupt(7, good, DATA_W'(1) << (p * 3));
      doRead(7, 0, d, e, v);
      check("R3", "single bit group", e, ILV'(1) << ((p * 3) % ILV));
      check("R7", "sticky set", errSticky, 1);
    end
    clearSticky();
  endtask

  task automatic testBurst();
    logic [DATA_W-1:0] d; logic [ILV-1:0] e; logic v;
    logic [DATA_W-1:0] good = 32'h0F0F_5A5A;
    corrupt(9, good, 32'hF << 5);
    doRead(9, 0, d, e, v);
    check("R4", "4-bit burst at 5", e, 4'b1111);
    corrupt(9, good, 32'h7 << 9);
    doRead(9, 0, d, e, v);
    check("R4", "3-bit burst at 9", e, 4'b1110);
    corrupt(9, good, 32'h3 << 30);
    doRead(9, 0, d, e, v);
    check("R4", "2-bit burst at 30", e, 4'b1100);
    clearSticky();
  endtask

  task automatic testClearPriority();
    logic [DATA_W-1:0] d; logic [ILV-1:0] e; logic v;
    logic [DATA_W-1:0] good = 32'h8000_0001;
    corrupt(10, good, 32'h1);
    doRead(10, 1, d, e, v);
    check("R8", "error wins over clear", errSticky, 1);
    repeat (3) @(negedge clk);
    check("R7", "sticky holds", errSticky, 1);
    clearSticky();
  endtask

  task automatic testWriteInject();
    logic [DATA_W-1:0] d; logic [ILV-1:0] e; logic v;
    doWrite(1, 32'hCAFE_0001, 0, '0);
    pulse(1, 0, 4'b0101);
    doRead(1, 0, d, e, v);
    check("R10", "read does not consume write arm", e, 0);
    doWrite(4, 32'hDEAD_BEEF, 0, '0);
    doWrite(5, 32'h0BAD_F00D, 0, '0);
    doRead(4, 0, d, e, v);
    check("R5", "injected write err", e, 4'b0101);
    check("R5", "injected write data", d, 32'hDEAD_BEEF);
    doRead(4, 0, d, e, v);
    check("R5", "stored err persists", e, 4'b0101);
    doRead(5, 0, d, e, v);
    check("R5", "following write clean", e, 0);
    doWrite(6, 32'h7777_1111, 1, 4'b1000);
    doRead(6, 0, d, e, v);
    check("R5", "coincident write pulse", e, 4'b1000);
    clearSticky();
  endtask

  task automatic testReadInject();
    logic [DATA_W-1:0] d; logic [ILV-1:0] e; logic v;
    pulse(0, 1, 4'b0010);
    doWrite(12, 32'h5555_AAAA, 0, '0);
    doRead(12, 0, d, e, v);
    check("R10", "write does not consume read arm", e, 4'b0010);
    check("R6", "read inject data intact", d, 32'h5555_AAAA);
    doRead(12, 0, d, e, v);
    check("R6", "read inject one read only", e, 0);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 12; injRd = 1; injMask = 4'b1001;
    @(negedge clk);
    idle();
    check("R6", "coincident read pulse", rdWordErr, 4'b1001);
    clearSticky();
  endtask

  initial begin
    idle();
    reqAddr = '0; reqWdata = '0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testBasic();
    testSingleBit();
    testBurst();
    testClearPriority();
    testWriteInject();
    testReadInject();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule